// File: doc/BRIEF.md
# Configuration Bus Sanity Probe

This block decides whether a configuration access path seems to work before the rest of the system trusts it. After a `start` pulse it either accepts the path at once or walks every device/function slot of bus 0 through a generic configuration read port. It stops at the first slot that looks like a real host. It finishes with a one-cycle `done` pulse, and `pass` tells whether the path was accepted.

There are two early exits. The first is a bypass flag. The second is a platform year at or above a cutoff, set by default to 2001. When neither applies, the probe reads the 16-bit class field of each slot. If that does not match, it reads the 16-bit vendor ID of the same slot. A read that comes back with an error moves the scan straight to the next slot.

The sequencer has five states:
- **IDLE** waits for `start`. It goes to **REPORT** (with pass) on an early exit, or to **RD_CLASS** to begin the scan.
- **RD_CLASS** goes to **REPORT** on a class hit, to **RD_VENDOR** on a miss, and to **ADVANCE** on an error.
- **RD_VENDOR** goes to **REPORT** on a vendor hit, and to **ADVANCE** on a miss or an error.
- **ADVANCE** goes to **RD_CLASS** for the next slot, or to **REPORT** (with fail) after the last slot.
- **REPORT** returns to **IDLE**.

Top module: `cfg_sanity_probe`

## Requirements
- R1: With `bypass_i` high when `start_i` is accepted in IDLE, the probe issues no read and raises `done_o` with `pass_o` high on the next cycle.
- R2: With `year_i` >= 2001 (and bypass low) at start, the probe issues no read and raises `done_o` with `pass_o` high on the next cycle. With `year_i` < 2001, a scan runs.
- R3: The scan visits device/function values 0 to 255 on bus 0 in ascending order. For each slot, the class read (offset 0x0A) comes before any vendor read (offset 0x00).
- R4: A class read that completes without error and returns 0x0600 (host bridge) or 0x0300 (VGA display) ends the scan with pass. No further read is issued.
- R5: After a class miss, the probe reads the vendor ID of the same slot. A value equal to `VENDOR_A` (default 0x1A2B) or `VENDOR_B` (default 0x3C4D) ends the scan with pass.
- R6: A read completed with `rd_err_i` high never yields a pass. The scan moves to the next slot, and after a class read error no vendor read is issued for that slot.
- R7: When all 256 slots end without a match, the probe raises `done_o` with `pass_o` low.
- R8: `done_o` is high for exactly one cycle per run, and `pass_o` is never high without `done_o`.
- R9: At most one read is outstanding. `rd_req_o` stays high with a stable device/function and offset until `rd_ack_i` is seen.
- R10: After reset, `done_o`, `pass_o` and `rd_req_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a probe; honoured only in IDLE |
| bypass_i | input | 1 | Skip all checks and report pass |
| year_i | input | 12 | Platform year |
| rd_req_o | output | 1 | Configuration read request, held until acknowledged |
| rd_devfn_o | output | 8 | Device/function of the read (bus 0 implied) |
| rd_offset_o | output | 8 | Register offset of the read |
| rd_ack_i | input | 1 | Read completes in this cycle |
| rd_err_i | input | 1 | The completing read failed |
| rd_data_i | input | 16 | 16-bit read data, valid with `rd_ack_i` |
| done_o | output | 1 | One-cycle completion pulse |
| pass_o | output | 1 | Result, valid with `done_o` |

## Verification
The assertions assume the following of the responder:
- `rd_ack_i` is only meaningful while `rd_req_o` is high.
- `rd_err_i` and `rd_data_i` are only looked at in a cycle where `rd_ack_i` is high.
- `start_i` has an effect only in IDLE.

The bench responder keeps to these rules. It raises the acknowledge after a chosen latency of 0 to 2 cycles, with a fresh count for each request, and drops it the cycle after. It also checks each acknowledged read against its own walk of the slot table. That walk covers ascending order, class before vendor, and no vendor read after a class error. Every scan pattern is generated arithmetically from the slot number.

// File: rtl/cfg_sanity_probe_pkg.sv
package cfg_sanity_probe_pkg;

    typedef enum logic [2:0] {
        S_IDLE      = 3'd0,
        S_RD_CLASS  = 3'd1,
        S_RD_VENDOR = 3'd2,
        S_ADVANCE   = 3'd3,
        S_REPORT    = 3'd4
    } probe_state_e;

endpackage

// File: rtl/cfg_probe_walker.sv
module cfg_probe_walker #(
    parameter int SLOT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear_i,
    input  logic              step_i,
    output logic [SLOT_W-1:0] slot_o,
    output logic              last_o
);
    localparam logic [SLOT_W-1:0] SLOT_LAST = {SLOT_W{1'b1}};

    logic [SLOT_W-1:0] slot_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            slot_q <= '0;
        end else if (clear_i) begin
            slot_q <= '0;
        end else if (step_i && slot_q != SLOT_LAST) begin
            slot_q <= slot_q + 1'b1;
        end
    end

    assign slot_o = slot_q;
    assign last_o = (slot_q == SLOT_LAST);

    // The slot only moves by one upward, or back to zero on clear
    AST_SLOT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && !clear_i && !last_o) |=> slot_o == $past(slot_o) + 1'b1)
        else $error("slot did not advance by one"); // R3

endmodule

// File: rtl/cfg_probe_match.sv
module cfg_probe_match #(
    parameter int          DATA_W     = 16,
    parameter logic [15:0] HOST_CLASS = 16'h0600,
    parameter logic [15:0] VGA_CLASS  = 16'h0300,
    parameter logic [15:0] VENDOR_A   = 16'h1A2B,
    parameter logic [15:0] VENDOR_B   = 16'h3C4D
) (
    input  logic              class_phase_i,
    input  logic [DATA_W-1:0] data_i,
    output logic              hit_o
);
    logic class_hit;
    logic vendor_hit;

    always_comb begin
        class_hit  = (data_i == DATA_W'(HOST_CLASS)) || (data_i == DATA_W'(VGA_CLASS));
        vendor_hit = (data_i == DATA_W'(VENDOR_A))   || (data_i == DATA_W'(VENDOR_B));
        hit_o      = class_phase_i ? class_hit : vendor_hit;
    end

endmodule

// File: rtl/cfg_sanity_probe.sv
module cfg_sanity_probe
    import cfg_sanity_probe_pkg::*;
#(
    parameter int          YEAR_W      = 12,
    parameter int          CUTOFF_YEAR = 2001,
    parameter int          SLOT_W      = 8,
    parameter int          OFS_W       = 8,
    parameter int          DATA_W      = 16,
    parameter logic [7:0]  CLASS_OFS   = 8'h0A,
    parameter logic [7:0]  VENDOR_OFS  = 8'h00,
    parameter logic [15:0] HOST_CLASS  = 16'h0600,
    parameter logic [15:0] VGA_CLASS   = 16'h0300,
    parameter logic [15:0] VENDOR_A    = 16'h1A2B,
    parameter logic [15:0] VENDOR_B    = 16'h3C4D
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              bypass_i,
    input  logic [YEAR_W-1:0] year_i,
    output logic              rd_req_o,
    output logic [SLOT_W-1:0] rd_devfn_o,
    output logic [OFS_W-1:0]  rd_offset_o,
    input  logic              rd_ack_i,
    input  logic              rd_err_i,
    input  logic [DATA_W-1:0] rd_data_i,
    output logic              done_o,
    output logic              pass_o
);
    localparam logic [YEAR_W-1:0] YEAR_CUT = YEAR_W'(CUTOFF_YEAR);

    probe_state_e state_q, state_d;
    logic         result_q, result_d;
    logic         walk_clear, walk_step, walk_last;
    logic         early_ok;
    logic         data_hit;
    logic         in_class;

    assign early_ok = bypass_i || (year_i >= YEAR_CUT);
    assign in_class = (state_q == S_RD_CLASS);

    cfg_probe_walker #(
        .SLOT_W (SLOT_W)
    ) u_walker (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (walk_clear),
        .step_i  (walk_step),
        .slot_o  (rd_devfn_o),
        .last_o  (walk_last)
    );

    cfg_probe_match #(
        .DATA_W     (DATA_W),
        .HOST_CLASS (HOST_CLASS),
        .VGA_CLASS  (VGA_CLASS),
        .VENDOR_A   (VENDOR_A),
        .VENDOR_B   (VENDOR_B)
    ) u_match (
        .class_phase_i (in_class),
        .data_i        (rd_data_i),
        .hit_o         (data_hit)
    );

    // next-state logic
    always_comb begin
        state_d    = state_q;
        result_d   = result_q;
        walk_clear = 1'b0;
        walk_step  = 1'b0;
        unique case (state_q)
            S_IDLE: begin
                if (start_i) begin
                    if (early_ok) begin
                        result_d = 1'b1;
                        state_d  = S_REPORT;
                    end else begin
                        result_d   = 1'b0;
                        walk_clear = 1'b1;
                        state_d    = S_RD_CLASS;
                    end
                end
            end
            S_RD_CLASS: begin
                if (rd_ack_i) begin
                    if (rd_err_i) begin
                        state_d = S_ADVANCE;
                    end else if (data_hit) begin
                        result_d = 1'b1;
                        state_d  = S_REPORT;
                    end else begin
                        state_d = S_RD_VENDOR;
                    end
                end
            end
            S_RD_VENDOR: begin
                if (rd_ack_i) begin
                    if (!rd_err_i && data_hit) begin
                        result_d = 1'b1;
                        state_d  = S_REPORT;
                    end else begin
                        state_d = S_ADVANCE;
                    end
                end
            end
            S_ADVANCE: begin
                if (walk_last) begin
                    result_d = 1'b0;
                    state_d  = S_REPORT;
                end else begin
                    walk_step = 1'b1;
                    state_d   = S_RD_CLASS;
                end
            end
            S_REPORT: begin
                state_d = S_IDLE;
            end
            default: begin
                state_d = S_IDLE;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= S_IDLE;
            result_q <= 1'b0;
        end else begin
            state_q  <= state_d;
            result_q <= result_d;
        end
    end

    // outputs
    always_comb begin
        rd_req_o    = (state_q == S_RD_CLASS) || (state_q == S_RD_VENDOR);
        rd_offset_o = (state_q == S_RD_VENDOR) ? OFS_W'(VENDOR_OFS) : OFS_W'(CLASS_OFS);
        done_o      = (state_q == S_REPORT);
        pass_o      = done_o && result_q;
    end

    AST_BYPASS_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_IDLE && start_i && bypass_i) |=> (done_o && pass_o && !rd_req_o))
        else $error("bypass did not pass at once"); // R1

    AST_YEAR_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_IDLE && start_i && year_i >= YEAR_CUT) |=> (done_o && pass_o && !rd_req_o))
        else $error("late year did not pass at once"); // R2

    AST_CLASS_HIT_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req_o && rd_ack_i && !rd_err_i && rd_offset_o == OFS_W'(CLASS_OFS) &&
         (rd_data_i == DATA_W'(HOST_CLASS) || rd_data_i == DATA_W'(VGA_CLASS)))
        |=> (done_o && pass_o && !rd_req_o))
        else $error("class hit did not end the scan"); // R4

    AST_CLASS_ERR_SKIP: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req_o && rd_ack_i && rd_err_i && rd_offset_o == OFS_W'(CLASS_OFS))
        |=> (!rd_req_o && !done_o))
        else $error("class error did not skip the slot"); // R6

    AST_EXHAUST_FAIL: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_ADVANCE && walk_last) |=> (done_o && !pass_o))
        else $error("exhausted scan did not fail"); // R7

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o)
        else $error("done held more than one cycle"); // R8

    AST_PASS_QUAL: assert property (@(posedge clk) disable iff (!rst_n)
        pass_o |-> done_o)
        else $error("pass without done"); // R8

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req_o && !rd_ack_i) |=> (rd_req_o && $stable(rd_devfn_o) && $stable(rd_offset_o)))
        else $error("request dropped or changed before acknowledge"); // R9

endmodule

// File: tb/cfg_sanity_probe_test.sv
module cfg_sanity_probe_test;

    localparam int CLK_PERIOD = 10;
    localparam logic [15:0] VA = 16'h1A2B;
    localparam logic [15:0] VB = 16'h3C4D;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic        bypass_i = 1'b0;
    logic [11:0] year_i = 12'd1995;
    logic        rd_req_o;
    logic [7:0]  rd_devfn_o;
    logic [7:0]  rd_offset_o;
    logic        rd_ack_i = 1'b0;
    logic        rd_err_i = 1'b0;
    logic [15:0] rd_data_i = 16'h0;
    logic        done_o;
    logic        pass_o;

    int checks = 0;
    int fails  = 0;

    int scen = 0;
    int lat_cfg = 0;
    int lat_cnt = 0;
    int reads = 0;
    int order_err = 0;
    int m_slot = 0;
    bit m_class = 1'b1;

    always #(CLK_PERIOD/2) clk = ~clk;

    cfg_sanity_probe uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .bypass_i    (bypass_i),
        .year_i      (year_i),
        .rd_req_o    (rd_req_o),
        .rd_devfn_o  (rd_devfn_o),
        .rd_offset_o (rd_offset_o),
        .rd_ack_i    (rd_ack_i),
        .rd_err_i    (rd_err_i),
        .rd_data_i   (rd_data_i),
        .done_o      (done_o),
        .pass_o      (pass_o)
    );

    // slot table per scenario: {err, data}
    function automatic logic [16:0] slot_resp(int sc, int d, bit cls);
        logic        err;
        logic [15:0] v;
        err = 1'b0;
        v   = cls ? 16'h0101 : 16'hFFFF;
        case (sc)
            0: if (cls) err = 1'b1;
            1: if (cls && d == 37) v = 16'h0600;
            2: begin
                if (cls && (d % 2) == 1) err = 1'b1;
                if (cls && d == 200) v = 16'h0300;
            end
            3: begin
                if (cls) v = 16'h0200;
                if (!cls && d == 255) v = VA;
            end
            4: begin
                if (cls && d == 5) begin err = 1'b1; v = 16'h0600; end
                if (cls && d == 10) err = 1'b1;
                if (!cls && d == 10) v = VA;
                if (!cls && d < 100) err = 1'b1;
                if (!cls && d == 128) v = VB;
            end
            6: if (cls && d == 0) v = 16'h0600;
            default: ;
        endcase
        return {err, v};
    endfunction

    // expected outcome from the requirements
    task automatic expect_walk(input int sc, output bit ok, output int n);
        logic [16:0] r;
        ok = 1'b0;
        n  = 0;
        for (int d = 0; d < 256; d++) begin
            r = slot_resp(sc, d, 1'b1);
            n++;
            if (!r[16]) begin
                if (r[15:0] == 16'h0600 || r[15:0] == 16'h0300) begin ok = 1'b1; return; end
                r = slot_resp(sc, d, 1'b0);
                n++;
                if (!r[16] && (r[15:0] == VA || r[15:0] == VB)) begin ok = 1'b1; return; end
            end
        end
    endtask

    // responder: drives at negedge, follows its own walk of the table
    always @(negedge clk) begin
        logic [16:0] r;
        if (rd_ack_i) begin
            rd_ack_i = 1'b0;
            lat_cnt  = 0;
        end else if (rd_req_o) begin
            if (lat_cnt >= lat_cfg) begin
                if (int'(rd_devfn_o) != m_slot || rd_offset_o != (m_class ? 8'h0A : 8'h00))
                    order_err++;
                r = slot_resp(scen, int'(rd_devfn_o), rd_offset_o == 8'h0A);
                rd_ack_i  = 1'b1;
                rd_err_i  = r[16];
                rd_data_i = r[15:0];
                reads++;
                if (m_class) begin
                    if (r[16]) m_slot++;
                    else m_class = 1'b0;
                end else begin
                    m_class = 1'b1;
                    m_slot++;
                end
            end else begin
                lat_cnt++;
            end
        end else begin
            lat_cnt = 0;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic run(input int sc, input int lat, input bit byp, input int yr,
                       input bit exp_pass, input int exp_reads, input string req);
        int  wait_c;
        bit  seen;
        @(negedge clk);
        scen = sc; lat_cfg = lat; reads = 0; order_err = 0;
        m_slot = 0; m_class = 1'b1;
        bypass_i = byp; year_i = 12'(yr);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        seen = 1'b0;
        wait_c = 0;
        while (!seen && wait_c < 5000) begin
            if (done_o) seen = 1'b1;
            else begin
                @(negedge clk);
                wait_c++;
            end
        end
        check(seen, {req, " done seen"}, int'(seen), 1);
        check(pass_o == exp_pass, {req, " pass"}, int'(pass_o), int'(exp_pass));
        check(reads == exp_reads, {req, " read count"}, reads, exp_reads);
        check(order_err == 0, "R3 read order", order_err, 0);
        @(negedge clk);
        check(!done_o && !pass_o, "R8 done one cycle", int'(done_o), 0);
    endtask

    initial begin
        bit ep;
        int en;
        repeat (3) @(negedge clk);
        check(!done_o && !pass_o && !rd_req_o, "R10 reset outputs",
              int'({done_o, pass_o, rd_req_o}), 0);
        rst_n = 1'b1;
        @(negedge clk);

        run(0, 0, 1'b1, 1995, 1'b1, 0, "R1 bypass");
        run(0, 0, 1'b0, 2001, 1'b1, 0, "R2 year 2001");
        run(0, 1, 1'b0, 4095, 1'b1, 0, "R2 year max");
        expect_walk(6, ep, en);
        run(6, 2, 1'b0, 2000, ep, en, "R2 year 2000 scans");
        expect_walk(0, ep, en);
        run(0, 0, 1'b0, 1990, ep, en, "R6 all class errors");
        expect_walk(1, ep, en);
        run(1, 1, 1'b0, 1990, ep, en, "R4 host class");
        expect_walk(2, ep, en);
        run(2, 2, 1'b0, 1990, ep, en, "R4 vga class");
        expect_walk(3, ep, en);
        run(3, 0, 1'b0, 1990, ep, en, "R5 vendor A last slot");
        expect_walk(4, ep, en);
        run(4, 1, 1'b0, 1990, ep, en, "R5 R6 vendor B after errors");
        expect_walk(5, ep, en);
        run(5, 0, 1'b0, 1990, ep, en, "R7 exhausted");
        run(5, 2, 1'b0, 1990, ep, en, "R9 slow acks");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule